// File: doc/BRIEF.md
# Frame Buffer Control and Interrupt Register Window

This block is the register window that software uses to control a frame buffer. The window is 32 bytes long. Byte offsets in the lower half are unmapped. Byte offsets in the upper half form a bank of byte registers:

- Bank index 0 is the control register. Its bit 7 arms the end-of-frame interrupt.
- Bank index 1 is the status register. It combines fixed identity bits with a sticky pending flag.
- The remaining indices are general read/write bytes. These include the cursor start, cursor end and video control bytes at offsets 0x12, 0x13 and 0x14.

The video side drives a one-cycle `frame_end` pulse at the end of each frame. If the control enable bit is set, that pulse latches the pending flag. The `irq` output is a registered level that follows the flag. Software acknowledges the interrupt by writing any value to the status register.

The register bus is a plain single-beat port with no back-pressure. A request is taken in every cycle in which `bus_valid` is high. A write takes effect at that clock edge. A read returns its byte on `bus_rdata` one cycle later, and `bus_rvalid` is high for exactly that cycle. The bus master must be ready to take read data in the cycle after the request.

Top module: `fbreg_ctrl_win`

## Requirements
- R1: After reset, `irq` is 0, the control register reads 0x00, the status register reads 0x61, and every general byte register reads 0x00.
- R2: A write to offset 0x10 stores the byte in the control register, and a later read of 0x10 returns it.
- R3: A read of offset 0x11 returns 0x61 in bits 6..0 (monitor sense code 0x60 ORed with colour board identity 0x01) and the pending flag in bit 7. The written data is never stored there.
- R4: When `frame_end` is high at a clock edge and control bit 7 (value before any write in that same cycle) is set, the pending flag and `irq` are 1 after that edge. When the enable bit is clear, `frame_end` has no effect.
- R5: Once set, the pending flag stays set through further frame ends, reads, and writes to any offset other than 0x11.
- R6: A write of any data to offset 0x11 clears the pending flag, and `irq` is 0 after that edge.
- R7: If an armed `frame_end` and a status write fall in the same cycle, the flag stays set and `irq` stays 1.
- R8: Offsets 0x12 to 0x1F are fourteen independent read/write bytes.
- R9: Offsets 0x00 to 0x0F read as 0x00, and writes to them change no register and do not change `irq`.
- R10: A read request gives `bus_rvalid` high for exactly the next cycle, with the data on `bus_rdata` in that cycle. Writes and idle cycles give `bus_rvalid` low one cycle later.
- R11: `irq` always equals the pending bit that a status read returns.
- R12: Clearing control bit 7 while the flag is set does not clear the flag or `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the window |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read data strobe, one cycle after the read request |
| frame_end | input | 1 | End-of-frame pulse |
| irq | output | 1 | Level interrupt, registered, follows the pending flag |

## Verification
Three kinds of result each have a fixed delay after the edge that samples the stimulus:

- A write changes register state at that edge.
- `irq` reflects an armed frame end or a status write right after that edge.
- Read data and its strobe appear in the cycle after the request.

The bench drives inputs on the falling edge. On the next falling edge it compares `irq`, `bus_rvalid` and `bus_rdata` against a reference model, updated one step per cycle, that computes the read value from its state before that cycle's update. Random traffic is mixed with directed sequences for the same-cycle collision, for disabling the enable while the flag is set, and for unmapped offsets.

// File: rtl/fbreg_pkg.sv
package fbreg_pkg;
  localparam int DW          = 8;
  localparam int CTRL_IDX    = 0;   // bank index of control byte
  localparam int STAT_IDX    = 1;   // bank index of status byte
  localparam int IRQ_EN_BIT  = 7;
  localparam int PEND_BIT    = 7;
  localparam logic [DW-1:0] STAT_FIXED = 8'h61; // sense code | colour id

  typedef struct packed {
    logic       valid;
    logic       write;
    logic [DW-1:0] wdata;
  } bus_cmd_t;
endpackage

// File: rtl/fbreg_decode.sv
module fbreg_decode
  import fbreg_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int NREG  = 1 << (ADDR_W - 1),
  localparam int IDX_W = ADDR_W - 1
) (
  input  bus_cmd_t          cmd,
  input  logic [ADDR_W-1:0] addr,
  output logic              in_bank,
  output logic [IDX_W-1:0]  idx,
  output logic              rd_fire,
  output logic              stat_wr,
  output logic [NREG-1:0]   store_we
);
  assign in_bank = addr[ADDR_W-1];
  assign idx     = addr[IDX_W-1:0];
  assign rd_fire = cmd.valid && !cmd.write;
  assign stat_wr = cmd.valid && cmd.write && in_bank && (idx == IDX_W'(STAT_IDX));

  for (genvar i = 0; i < NREG; i++) begin : g_we
    if (i == STAT_IDX) begin : g_stat
      assign store_we[i] = 1'b0;
    end else begin : g_plain
      assign store_we[i] = cmd.valid && cmd.write && in_bank && (idx == IDX_W'(i));
    end
  end
endmodule

// File: rtl/fbreg_store.sv
module fbreg_store
  import fbreg_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          we,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  q
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == STAT_IDX) begin : g_hole
      assign q[i] = '0;
    end else begin : g_byte
      logic [DW-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     r_q <= '0;
        else if (we[i]) r_q <= wdata;
      end
      assign q[i] = r_q;
    end
  end
endmodule

// File: rtl/fbreg_irq.sv
module fbreg_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_end,
  input  logic irq_en,
  input  logic ack,
  output logic pending
);
  logic pend_q;
  // a fresh armed frame end wins over an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_q <= 1'b0;
    else if (frame_end && irq_en) pend_q <= 1'b1;
    else if (ack)                 pend_q <= 1'b0;
  end
  assign pending = pend_q;
endmodule

// File: rtl/fbreg_ctrl_win.sv
module fbreg_ctrl_win
  import fbreg_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int NREG  = 1 << (ADDR_W - 1),
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  input  logic              frame_end,
  output logic              irq
);
  bus_cmd_t                 cmd;
  logic                     in_bank, rd_fire, stat_wr, pending;
  logic [IDX_W-1:0]         idx;
  logic [NREG-1:0]          store_we;
  logic [NREG-1:0][DW-1:0]  bank_q;
  logic [DW-1:0]            ctrl_q, rd_mux, rdata_q;
  logic                     rvalid_q;

  assign cmd = '{valid: bus_valid, write: bus_write, wdata: bus_wdata};

  fbreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cmd(cmd), .addr(bus_addr), .in_bank(in_bank), .idx(idx),
    .rd_fire(rd_fire), .stat_wr(stat_wr), .store_we(store_we)
  );

  fbreg_store #(.NREG(NREG)) u_store (
    .clk(clk), .rst_n(rst_n), .we(store_we), .wdata(cmd.wdata), .q(bank_q)
  );

  assign ctrl_q = bank_q[CTRL_IDX];

  fbreg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
    .irq_en(ctrl_q[IRQ_EN_BIT]), .ack(stat_wr), .pending(pending)
  );

  always_comb begin
    rd_mux = '0;
    if (in_bank) begin
      if (idx == IDX_W'(STAT_IDX)) begin
        rd_mux = STAT_FIXED;
        rd_mux[PEND_BIT] = pending;
      end else begin
        rd_mux = bank_q[idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_fire;
      if (rd_fire) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign irq        = pending;
endmodule

// File: rtl/fbreg_ctrl_win_chk.sv
module fbreg_ctrl_win_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              bus_rvalid,
  input logic              frame_end,
  input logic              irq,
  input logic              en_q
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'((1 << (ADDR_W - 1)) + 1);

  logic rd_req, stat_rd, low_rd;
  assign rd_req  = bus_valid && !bus_write;
  assign stat_rd = rd_req && (bus_addr == STAT_A);
  assign low_rd  = rd_req && !bus_addr[ADDR_W-1];

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(frame_end && en_q));
  // R6
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_valid && bus_write && bus_addr == STAT_A));
  // R7
  fe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && en_q) |=> irq);
  // R10
  rvalid_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> bus_rvalid);
  // R10
  rvalid_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !bus_rvalid);
  // R3
  stat_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (bus_rdata[6:0] == 7'h61));
  // R11
  stat_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (bus_rdata[7] == $past(irq)));
  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_rd |=> (bus_rdata == 8'h00));
endmodule

bind fbreg_ctrl_win fbreg_ctrl_win_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .frame_end(frame_end), .irq(irq), .en_q(ctrl_q[7])
);

// File: tb/fbreg_ctrl_win_tb.sv
module fbreg_ctrl_win_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, frame_end = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid, irq;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_reg [16];
  logic       m_pend;
  logic       p_rd;
  logic [7:0] p_data;
  string      p_tag, irq_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbreg_ctrl_win u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .frame_end(frame_end), .irq(irq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(logic [4:0] a);
    if (!a[4])          return 8'h00;           // R9
    if (a[3:0] == 4'd1) return {m_pend, 7'h61}; // R3
    return m_reg[a[3:0]];                       // R2 / R8
  endfunction

  function automatic string read_tag(logic [4:0] a);
    if (!a[4])          return "R9";
    if (a[3:0] == 4'd0) return "R2";
    if (a[3:0] == 4'd1) return "R3";
    return "R8";
  endfunction

  // one bus/frame step: drive at negedge, check previous step at this negedge
  task automatic step(logic v, logic w, logic [4:0] a, logic [7:0] d, logic fe);
    logic armed, ack, new_pend;
    @(negedge clk);
    check("R10", {7'd0, bus_rvalid}, {7'd0, p_rd});
    if (p_rd) check(p_tag, bus_rdata, p_data);
    check(irq_tag, {7'd0, irq}, {7'd0, m_pend});
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; frame_end = fe;
    p_rd = v && !w;
    if (p_rd) begin p_data = model_read(a); p_tag = read_tag(a); end
    armed = fe && m_reg[0][7];
    ack   = v && w && (a == 5'h11);
    new_pend = armed ? 1'b1 : (ack ? 1'b0 : m_pend);
    if (armed && ack)          irq_tag = "R7";
    else if (armed && !m_pend) irq_tag = "R4";
    else if (ack && m_pend)    irq_tag = "R6";
    else                       irq_tag = "R5";
    if (v && w && a[4] && a[3:0] != 4'd1) m_reg[a[3:0]] = d;
    m_pend = new_pend;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 16; i++) m_reg[i] = '0;
    m_pend = 1'b0; p_rd = 1'b0; p_data = '0; p_tag = "R1"; irq_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    check("R1", {7'd0, irq}, 8'h00);
    step(1, 0, 5'h10, 0, 0); p_tag = "R1";
    step(1, 0, 5'h11, 0, 0); p_tag = "R1";
    step(1, 0, 5'h1F, 0, 0); p_tag = "R1";
    // R2 / R4: arm and fire
    step(1, 1, 5'h10, 8'h80, 0);
    step(0, 0, 0, 0, 1);
    step(1, 0, 5'h11, 0, 0);              // R11: reads 0xE1 while irq high
    step(0, 0, 0, 0, 1);                  // R5: second frame end keeps flag
    step(1, 1, 5'h05, 8'hFF, 0);          // R9: unmapped write, flag unchanged
    step(1, 1, 5'h10, 8'h00, 0);          // R12: disable while pending
    step(1, 0, 5'h05, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R12", {7'd0, irq}, 8'h01);
    step(1, 1, 5'h11, 8'h00, 0);          // R6: any data clears
    step(1, 1, 5'h10, 8'h80, 0);
    step(1, 1, 5'h11, 8'h5A, 1);          // R7: collision keeps flag
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R7", {7'd0, irq}, 8'h01);
    step(1, 1, 5'h11, 8'hFF, 0);
    step(1, 1, 5'h11, 8'hFF, 1);          // R4: disabled? no, ctrl still armed
    step(1, 1, 5'h10, 8'h00, 0);
    step(1, 1, 5'h11, 8'h00, 0);
    step(0, 0, 0, 0, 1);                  // R4: disabled frame end ignored
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    check("R4", {7'd0, irq}, 8'h00);
    // R8: fill and read back general bytes
    for (int i = 2; i < 16; i++) step(1, 1, 5'(16 + i), 8'(i * 17 + 3), 0);
    for (int i = 2; i < 16; i++) step(1, 0, 5'(16 + i), 0, 0);
    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [4:0] a;
      a = ($urandom % 4 == 0) ? 5'h11 : ($urandom % 6 == 0 ? 5'h10 : 5'($urandom));
      step(($urandom % 4) != 0, $urandom % 2 == 1, a, 8'($urandom), ($urandom % 5) == 0);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1;
    finish_run();
  end
endmodule